// File: doc/BRIEF.md
# Serial EEPROM Emulator Behind a Register Port

This block imitates a three-wire serial EEPROM that holds 128 words of 16 bits. Software operates it by bit-banging. Each write to one 8-bit port register sets chip-select, the serial clock and data-in. A read of the same register returns those bits together with the data-out line. A clock edge is therefore not a real pin transition. It is detected when a port write changes the clock bit relative to the previously stored port value.

The port is hidden behind a two-part unlock. One write region must last have received 0x0A and another region must last have received 0x40. While either part is missing, the port reads as 0xFF and ignores writes.

Commands consist of a start bit, a 2-bit opcode and a 7-bit word address. When the opcode is 00, the two most significant address bits select an extended command. The supported commands are read, write, erase, write-all, erase-all, write-enable and write-disable. Storage is a register array that resets to all ones.

Top module: `ser_eeprom_emu`

## Requirements
- R1: A write with wr_sel=0 and data 0x0A sets the first unlock half, and any other data clears it. A write with wr_sel=1 and data 0x40 sets the second half, and any other data clears it. The port (wr_sel=2) is accessible only while both halves are set.
- R2: While locked, port_rd reads 0xFF and port writes leave the stored port value unchanged.
- R3: In a port write, a 0-to-1 change of chip-select (bit 7) returns the protocol to idle and abandons any partial command or data.
- R4: A clock rising edge is a port write that takes bit 6 from 0 to 1. In idle, a rising edge with data-in (bit 1) at 1 is the start bit. The next 10 rising edges shift data-in into a 10-bit command c[9:0]. If c[9:8] is nonzero, it is the opcode: 01 write, 10 read, 11 erase. The word address is c[6:0].
- R5: With c[9:8]=00, c[7:6] selects the extended command: 00 write-disable, 01 write-all, 10 erase-all, 11 write-enable. Writing is disabled after reset. While writing is disabled, write, erase, write-all and erase-all leave the array unchanged.
- R6: A write takes 16 more data bits, MSB first, and stores them at the address after the 16th rising edge.
- R7: An erase sets the addressed word to 0xFFFF on the edge that completes the command.
- R8: Write-all takes 16 data bits and stores them in every word. Erase-all sets every word to 0xFFFF.
- R9: On the edge that completes a read command, data-out (bit 0) becomes 0 as a dummy bit. The next 16 rising edges present the word MSB first. The protocol then returns to idle.
- R10: Data-out reads 1 unless it is being driven. A port write that makes a clock falling edge while chip-select is 1 keeps the previous data-out value.
- R11: After reset the port is locked, the stored port value is 0x01, and every word reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Write region: 0 enable key, 1 second key, 2 serial port |
| wr_data | input | 8 | Write data; for the port bit 7 chip-select, bit 6 clock, bit 1 data-in |
| port_rd | output | 8 | Port read value; bit 0 data-out, 0xFF when locked |

## Verification
Every write is registered on the clock edge where wr_valid is high. The new port value, including data-out, is visible on port_rd as soon as that edge has passed. The unlock state follows the same timing. The bench therefore drives each write on a falling clock and samples port_rd on the next falling clock, one edge later. Array effects cannot be observed directly, so they are checked by complete serial read transactions issued after the command that changed them.

// File: rtl/ser_eeprom_emu.sv
module ser_eeprom_emu #(
  parameter int WORDS  = 128,
  parameter int WIDTH  = 16,
  parameter logic [7:0] KEY_A = 8'h0A,
  parameter logic [7:0] KEY_B = 8'h40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] port_rd
);
  localparam int ADDR_W   = $clog2(WORDS);
  localparam int CMD_BITS = ADDR_W + 3;
  localparam int CNT_W    = $clog2(WIDTH + 1);

  typedef enum logic [4:0] {
    S_IDLE  = 5'h00,
    S_CMD   = 5'h01,
    S_DOUT  = 5'h02,
    S_WDIS  = 5'h10,
    S_WALL  = 5'h11,
    S_EALL  = 5'h12,
    S_WENA  = 5'h13,
    S_WRITE = 5'h14,
    S_READ  = 5'h18,
    S_ERASE = 5'h1C
  } st_e;

  st_e               st_q, st_n;
  logic [WIDTH-1:0]  sr_q, sr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              wen_q, wen_n;
  logic              en_q, key_q;
  logic [7:0]        port_q;
  logic [WIDTH-1:0]  mem_q [WORDS];

  logic              do_n, mem_we, mem_all;
  logic [WIDTH-1:0]  mem_data;
  logic [3:0]        op;
  logic [4:0]        code;

  wire unlocked = en_q && key_q;
  wire port_wr  = wr_valid && (wr_sel == 2'd2) && unlocked;
  wire cs_new   = wr_data[7];
  wire ck_new   = wr_data[6];
  wire di       = wr_data[1];
  wire cs_old   = port_q[7];
  wire ck_old   = port_q[6];

  assign port_rd = unlocked ? port_q : 8'hFF;

  always_comb begin
    st_n     = st_q;
    sr_n     = sr_q;
    cnt_n    = cnt_q;
    addr_n   = addr_q;
    wen_n    = wen_q;
    do_n     = 1'b1;
    mem_we   = 1'b0;
    mem_all  = 1'b0;
    mem_data = '1;
    op       = '0;
    code     = '0;
    if (port_wr) begin
      if (!cs_old && cs_new) st_n = S_IDLE;
      if (!ck_old && ck_new) begin
        if (st_n == S_CMD || st_n == S_WRITE || st_n == S_WALL) begin
          sr_n  = {sr_n[WIDTH-2:0], di};
          cnt_n = cnt_n + 1'b1;
        end
        case (st_n)
          S_IDLE: if (di) begin
            st_n  = S_CMD;
            cnt_n = '0;
            sr_n  = '0;
          end
          S_CMD: if (cnt_n == CNT_W'(CMD_BITS)) begin
            op   = sr_n[CMD_BITS-1 -: 4];
            code = {1'b1, op};
            if (op[3:2] != 2'b00) code[1:0] = 2'b00;
            st_n   = st_e'(code);
            cnt_n  = '0;
            addr_n = sr_n[ADDR_W-1:0];
          end
          S_DOUT: begin
            do_n  = sr_n[WIDTH-1];
            sr_n  = {sr_n[WIDTH-2:0], 1'b0};
            cnt_n = cnt_n - 1'b1;
            if (cnt_n == '0) st_n = S_IDLE;
          end
          default: ;
        endcase
        case (st_n)
          S_WENA: begin
            wen_n = 1'b1;
            st_n  = S_IDLE;
          end
          S_WDIS: begin
            wen_n = 1'b0;
            st_n  = S_IDLE;
          end
          S_WRITE: if (cnt_n == CNT_W'(WIDTH)) begin
            mem_we   = wen_q;
            mem_data = sr_n;
            st_n     = S_IDLE;
          end
          S_ERASE: begin
            mem_we = wen_q;
            st_n   = S_IDLE;
          end
          S_WALL: if (cnt_n == CNT_W'(WIDTH)) begin
            mem_all  = wen_q;
            mem_data = sr_n;
            st_n     = S_IDLE;
          end
          S_EALL: begin
            mem_all = wen_q;
            st_n    = S_IDLE;
          end
          S_READ: begin
            cnt_n = CNT_W'(WIDTH);
            sr_n  = mem_q[addr_n];
            st_n  = S_DOUT;
            do_n  = 1'b0;
          end
          default: ;
        endcase
      end else if (cs_new && ck_old && !ck_new) begin
        do_n = port_q[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      key_q  <= 1'b0;
      port_q <= 8'h01;
      st_q   <= S_IDLE;
      sr_q   <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      wen_q  <= 1'b0;
    end else begin
      if (wr_valid && wr_sel == 2'd0) en_q  <= (wr_data == KEY_A);
      if (wr_valid && wr_sel == 2'd1) key_q <= (wr_data == KEY_B);
      if (port_wr) port_q <= {wr_data[7:1], do_n};
      st_q   <= st_n;
      sr_q   <= sr_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      wen_q  <= wen_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (mem_all) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_data;
    end else if (mem_we) begin
      mem_q[addr_n] <= mem_data;
    end
  end
endmodule

module ser_eeprom_emu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] port_rd,
  input logic [7:0] port_q,
  input logic       en_q,
  input logic       key_q,
  input logic [4:0] st_q
);
  wire pw = wr_valid && wr_sel == 2'd2 && en_q && key_q;

  // R1
  a_r1_bad_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd1 && wr_data != 8'h40) |=> port_rd == 8'hFF);
  // R1
  a_r1_bad_enable_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd0 && wr_data != 8'h0A) |=> port_rd == 8'hFF);
  // R2
  a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd2 && !(en_q && key_q)) |=> $stable(port_q));
  // R3
  a_r3_cs_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pw && wr_data[7] && !port_q[7] && !(wr_data[6] && !port_q[6])) |=> st_q == 5'h00);
  // R10
  a_r10_undriven_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pw && wr_data[6] == port_q[6]) |=> port_rd[0]);
  // R10
  a_r10_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pw && wr_data[7] && port_q[6] && !wr_data[6]) |=> port_q[0] == $past(port_q[0]));
  // R4
  a_r4_stored_states: assert property (@(posedge clk) disable iff (!rst_n)
    st_q inside {5'h00, 5'h01, 5'h02, 5'h11, 5'h14});
endmodule

bind ser_eeprom_emu ser_eeprom_emu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
  .wr_data(wr_data), .port_rd(port_rd), .port_q(port_q),
  .en_q(en_q), .key_q(key_q), .st_q(st_q)
);

// File: tb/ser_eeprom_emu_tb_top.sv
`timescale 1ns/1ps
module ser_eeprom_emu_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_valid = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] port_rd;
  int runs = 0, fails = 0;
  logic done = 0;
  logic [15:0] rw;
  logic dummy;

  always #2 clk = ~clk;

  ser_eeprom_emu dut_i (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_sel(wr_sel), .wr_data(wr_data), .port_rd(port_rd));

  // {sel, data, expected port_rd}
  localparam logic [17:0] VEC [10] = '{
    {2'd2, 8'hC2, 8'hFF}, {2'd0, 8'h0A, 8'hFF}, {2'd1, 8'h40, 8'h01},
    {2'd1, 8'h41, 8'hFF}, {2'd2, 8'hC2, 8'hFF}, {2'd1, 8'h40, 8'h01},
    {2'd0, 8'h0B, 8'hFF}, {2'd0, 8'h0A, 8'h01}, {2'd2, 8'h80, 8'h81},
    {2'd2, 8'h00, 8'h01}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic pw(input logic cs, input logic ck, input logic di);
    wr(2'd2, {cs, ck, 4'b0, di, 1'b0});
  endtask

  task automatic tick(input logic di);
    pw(1, 0, di); pw(1, 1, di);
  endtask

  task automatic cmd(input logic [9:0] v);
    pw(0, 0, 0); pw(1, 0, 0); tick(1);
    for (int i = 9; i >= 0; i--) tick(v[i]);
  endtask

  task automatic data16(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) tick(d[i]);
    pw(0, 0, 0);
  endtask

  task automatic rdw(input logic [6:0] a);
    cmd({3'b100, a});
    dummy = port_rd[0];
    for (int i = 15; i >= 0; i--) begin tick(0); rw[i] = port_rd[0]; end
    pw(0, 0, 0);
  endtask

  task automatic wrw(input logic [6:0] a, input logic [15:0] d);
    cmd({3'b010, a}); data16(d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 R2 locked after reset", {8'h0, port_rd}, 16'h00FF);
    for (int k = 0; k < 10; k++) begin
      wr(VEC[k][17:16], VEC[k][15:8]);
      chk($sformatf("R1 R2 unlock vector %0d", k), {8'h0, port_rd}, {8'h0, VEC[k][7:0]});
    end
    rdw(7'd5);
    chk("R11 reset word", rw, 16'hFFFF);
    chk("R9 dummy bit", {15'h0, dummy}, 16'h0);
    wrw(7'd5, 16'h1234); rdw(7'd5);
    chk("R5 write while disabled", rw, 16'hFFFF);
    cmd(10'b0011_000000); pw(0, 0, 0);
    wrw(7'd5, 16'h1234); wrw(7'd127, 16'hA5C3);
    rdw(7'd5);   chk("R6 R4 write addr 5", rw, 16'h1234);
    rdw(7'd127); chk("R6 R4 write addr 127", rw, 16'hA5C3);
    cmd({3'b110, 7'd5}); pw(0, 0, 0);
    rdw(7'd5);   chk("R7 erase addr 5", rw, 16'hFFFF);
    rdw(7'd127); chk("R7 neighbour kept", rw, 16'hA5C3);
    cmd(10'b0001_000000); data16(16'h0F0F);
    rdw(7'd0);   chk("R8 write-all word 0", rw, 16'h0F0F);
    rdw(7'd100); chk("R8 write-all word 100", rw, 16'h0F0F);
    cmd(10'b0010_000000); pw(0, 0, 0);
    rdw(7'd100); chk("R8 erase-all", rw, 16'hFFFF);
    wrw(7'd9, 16'h8001);
    cmd(10'b0000_000000); pw(0, 0, 0);
    wrw(7'd9, 16'h1111);
    cmd({3'b110, 7'd9}); pw(0, 0, 0);
    cmd(10'b0010_000000); pw(0, 0, 0);
    rdw(7'd9);   chk("R5 disabled write/erase", rw, 16'h8001);
    cmd(10'b0011_000000); pw(0, 0, 0);
    cmd({3'b010, 7'd9});
    for (int i = 0; i < 8; i++) tick(1);
    pw(0, 0, 0); pw(1, 0, 0);
    for (int i = 0; i < 8; i++) tick(0);
    pw(0, 0, 0);
    rdw(7'd9);   chk("R3 cs rise aborts write", rw, 16'h8001);
    pw(0, 0, 0);
    chk("R10 idle data-out high", {15'h0, port_rd[0]}, 16'h1);
    cmd({3'b100, 7'd9});
    chk("R9 dummy low", {15'h0, port_rd[0]}, 16'h0);
    pw(1, 0, 0);
    chk("R10 falling edge holds", {15'h0, port_rd[0]}, 16'h0);
    pw(1, 0, 0);
    chk("R10 no edge releases", {15'h0, port_rd[0]}, 16'h1);
    chk("R10 port bits", {8'h0, port_rd}, 16'h0081);
    pw(0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule